// File: doc/BRIEF.md
# Entropy Seed Register Access Unit

This block serves the entropy seed register on a processor's register access path. An access arrives as a one-cycle request. The request carries the current privilege level, the virtualization flag and whether the instruction form writes the register. A strap enables the entropy extension, and two enable bits from the security configuration register grant seed access to supervisor mode and to user mode. The unit decides whether the access is permitted or faults. There are two fault kinds: illegal instruction and virtual instruction. The unit answers one cycle after the request.

A permitted access returns a status word. The top two bits carry the operational status. When a fresh 16-bit entropy sample was offered by the entropy source on the access cycle, the low half carries that sample. Samples are taken over a valid/ready interface, and each sample is consumed at most once. When no sample is available the unit answers at once with a wait status instead of stalling. An error report from the source latches a permanent failure status until reset.

Privilege encoding on `priv`: 2'b00 user, 2'b01 supervisor, 2'b11 machine, 2'b10 reserved (always illegal unless a higher rule applies).

Top module: `seed_csr_unit`

## Requirements
- R1: When `ext_en` is low, every access faults with `rsp_illegal`=1, whatever the privilege level.
- R2: With `ext_en` high, an access with `acc_wr`=0 (read-only form) faults with `rsp_illegal`=1.
- R3: With `ext_en` and `acc_wr` high, a machine-mode access (`priv`=2'b11) is always permitted, whatever `virt` and the enable bits are.
- R4: A non-machine access with `virt`=1 always faults. The fault is `rsp_virt_fault`=1 when `sseed_en`=1, and `rsp_illegal`=1 otherwise.
- R5: A non-virtualized supervisor access (`priv`=2'b01) is permitted only when `sseed_en`=1, and faults illegal otherwise. `useed_en` has no effect on it.
- R6: A non-virtualized user access (`priv`=2'b00) is permitted only when `useed_en`=1, and faults illegal otherwise. `sseed_en` has no effect on it.
- R7: Every access gets exactly one response, with `rsp_valid` high on the cycle after `acc_valid`. At most one fault flag is set, and a faulted response has `rsp_rdata`=0.
- R8: A permitted access while `ent_valid`=1 and no failure returns status ES16 (bits 31:30 = 2'b10), zeros in bits 29:16 and the sample in bits 15:0. `ent_ready` is high for that access cycle only.
- R9: A permitted access while `ent_valid`=0 and no failure returns WAIT (bits 31:30 = 2'b01) with all other bits zero. It is answered on the next cycle and `ent_ready` stays low.
- R10: `ent_err` high in any cycle makes every later permitted access, including one on that same cycle, return DEAD (2'b11, other bits zero) without consuming a sample. This lasts until reset.
- R11: `acc_wdata` has no effect on the response.
- R12: `ent_ready` is never high outside a permitted ES16 access, so faulting accesses never consume a sample.
- R13: After reset `rsp_valid`, both fault flags, `rsp_rdata` and `ent_ready` are zero, and any earlier DEAD state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Entropy extension enable strap |
| sseed_en | input | 1 | Supervisor seed access enable |
| useed_en | input | 1 | User seed access enable |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualized mode active |
| acc_valid | input | 1 | Seed register access request |
| acc_wr | input | 1 | Access form writes the register |
| acc_wdata | input | 32 | Write data (ignored) |
| rsp_valid | output | 1 | Response valid |
| rsp_illegal | output | 1 | Illegal-instruction fault |
| rsp_virt_fault | output | 1 | Virtual-instruction fault |
| rsp_rdata | output | 32 | Read value: status and sample |
| ent_valid | input | 1 | Entropy sample available |
| ent_data | input | 16 | Entropy sample |
| ent_err | input | 1 | Entropy source failure |
| ent_ready | output | 1 | Sample consumed |

## Verification
The hardest case to reach is the permanent-failure latch. The source raises its error while no access is pending, and the DEAD status must stay visible later even when the source again offers valid samples. The stimulus pulses `ent_err` alone for one cycle. It then reads with a sample on offer and checks that DEAD comes back and `ent_ready` stays low. Only then does it reset and confirm that ES16 reads return. The ordering of the fault rules is covered with mixed enable settings, for example `useed_en` set with a supervisor access, or `virt` set together with machine mode.

// File: rtl/seed_csr_unit.sv
module seed_csr_unit #(
  parameter int XLEN     = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_en,
  input  logic                sseed_en,
  input  logic                useed_en,
  input  logic [1:0]          priv,
  input  logic                virt,
  input  logic                acc_valid,
  input  logic                acc_wr,
  input  logic [XLEN-1:0]     acc_wdata,
  output logic                rsp_valid,
  output logic                rsp_illegal,
  output logic                rsp_virt_fault,
  output logic [XLEN-1:0]     rsp_rdata,
  input  logic                ent_valid,
  input  logic [SAMPLE_W-1:0] ent_data,
  input  logic                ent_err,
  output logic                ent_ready
);
  localparam int PAD_W = XLEN - 2 - SAMPLE_W;
  localparam logic [1:0] ST_WAIT = 2'b01;
  localparam logic [1:0] ST_ES16 = 2'b10;
  localparam logic [1:0] ST_DEAD = 2'b11;
  localparam logic [1:0] PRV_U = 2'b00;
  localparam logic [1:0] PRV_S = 2'b01;
  localparam logic [1:0] PRV_M = 2'b11;

  logic            dead_q;
  logic            bad, vbad, grant, dead_now, take;
  logic [1:0]      status;
  logic [XLEN-1:0] word;
  logic            unused_wdata;

  assign unused_wdata = ^acc_wdata;

  always_comb begin
    bad  = 1'b0;
    vbad = 1'b0;
    if (!ext_en || !acc_wr)  bad = 1'b1;
    else if (priv == PRV_M)  bad = 1'b0;
    else if (virt) begin
      vbad = sseed_en;
      bad  = !sseed_en;
    end
    else if (priv == PRV_S)  bad = !sseed_en;
    else if (priv == PRV_U)  bad = !useed_en;
    else                     bad = 1'b1;
  end

  assign grant    = acc_valid && !bad && !vbad;
  assign dead_now = dead_q || ent_err;
  assign take     = grant && !dead_now && ent_valid;
  assign ent_ready = take;

  assign status = dead_now ? ST_DEAD : (ent_valid ? ST_ES16 : ST_WAIT);
  assign word   = grant ? {status, {PAD_W{1'b0}}, (take ? ent_data : {SAMPLE_W{1'b0}})}
                        : {XLEN{1'b0}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dead_q         <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_illegal    <= 1'b0;
      rsp_virt_fault <= 1'b0;
      rsp_rdata      <= '0;
    end else begin
      dead_q         <= dead_now;
      rsp_valid      <= acc_valid;
      rsp_illegal    <= acc_valid && bad;
      rsp_virt_fault <= acc_valid && vbad;
      rsp_rdata      <= word;
    end
  end
endmodule

// File: rtl/seed_csr_unit_chk.sv
module seed_csr_unit_chk #(
  parameter int XLEN     = 32,
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ext_en,
  input logic                sseed_en,
  input logic                useed_en,
  input logic [1:0]          priv,
  input logic                virt,
  input logic                acc_valid,
  input logic                acc_wr,
  input logic                rsp_valid,
  input logic                rsp_illegal,
  input logic                rsp_virt_fault,
  input logic [XLEN-1:0]     rsp_rdata,
  input logic                ent_valid,
  input logic                ent_err,
  input logic                ent_ready
);
  logic err_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) err_seen <= 1'b0;
    else        err_seen <= err_seen || ent_err;
  end

  assert_ext_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !ext_en |=> rsp_illegal);

  assert_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_wr |=> rsp_illegal);

  assert_machine_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && ext_en && acc_wr && priv == 2'b11 |=> !rsp_illegal && !rsp_virt_fault);

  assert_virt_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && ext_en && acc_wr && priv != 2'b11 && virt
    |=> (rsp_virt_fault == $past(sseed_en)) && (rsp_illegal != $past(sseed_en)));

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  assert_one_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_illegal && rsp_virt_fault));

  assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal || rsp_virt_fault |-> rsp_rdata == '0);

  assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[XLEN-3:SAMPLE_W] == '0);

  assert_dead_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen && rsp_valid && !rsp_illegal && !rsp_virt_fault |-> rsp_rdata[XLEN-1:XLEN-2] == 2'b11);

  assert_ready_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> acc_valid && ent_valid && !ent_err && !err_seen && ext_en && acc_wr);
endmodule

bind seed_csr_unit seed_csr_unit_chk #(.XLEN(XLEN), .SAMPLE_W(SAMPLE_W)) chk_i (.*);

// File: tb/seed_csr_unit_tb_top.sv
module seed_csr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b1, sseed_en = 1'b0, useed_en = 1'b0, virt = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic        acc_valid = 1'b0, acc_wr = 1'b1;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid, rsp_illegal, rsp_virt_fault, ent_ready;
  logic [31:0] rsp_rdata;
  logic        ent_valid = 1'b0, ent_err = 1'b0;
  logic [15:0] ent_data = '0;

  int n_chk = 0, n_bad = 0;
  logic rdy_seen;

  always #2 clk = ~clk;

  seed_csr_unit dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ent_err = 1'b0; ent_valid = 1'b0; acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // flags = {valid, illegal, virt_fault}
  task automatic access(string tag, logic [1:0] p, logic v, logic wr, logic [31:0] wd,
                        logic [2:0] exp_flags, logic [31:0] exp_data, logic exp_rdy);
    @(negedge clk);
    priv = p; virt = v; acc_wr = wr; acc_wdata = wd; acc_valid = 1'b1;
    #1 rdy_seen = ent_ready;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " flags"}, {29'd0, rsp_valid, rsp_illegal, rsp_virt_fault}, {29'd0, exp_flags});
    chk({tag, " data"}, rsp_rdata, exp_data);
    chk({tag, " ready"}, {31'd0, rdy_seen}, {31'd0, exp_rdy});
  endtask

  task automatic t_reset();
    chk("R13 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R13 faults", {30'd0, rsp_illegal, rsp_virt_fault}, 32'd0);
    chk("R13 rdata", rsp_rdata, 32'd0);
    chk("R13 ready", {31'd0, ent_ready}, 32'd0);
  endtask

  task automatic t_ext_off();
    ext_en = 1'b0; sseed_en = 1'b1; useed_en = 1'b1; ent_valid = 1'b1; ent_data = 16'h1234;
    access("R1 M", 2'b11, 1'b0, 1'b1, 0, 3'b110, 0, 1'b0);
    access("R1 U", 2'b00, 1'b0, 1'b1, 0, 3'b110, 0, 1'b0);
    access("R1 VS", 2'b01, 1'b1, 1'b1, 0, 3'b110, 0, 1'b0);
    ext_en = 1'b1;
  endtask

  task automatic t_read_only();
    ent_valid = 1'b1; ent_data = 16'h4321;
    access("R2 M ro", 2'b11, 1'b0, 1'b0, 0, 3'b110, 0, 1'b0);
    access("R2 S ro", 2'b01, 1'b0, 1'b0, 0, 3'b110, 0, 1'b0);
  endtask

  task automatic t_machine();
    sseed_en = 1'b0; useed_en = 1'b0; ent_valid = 1'b1; ent_data = 16'hA5A5;
    access("R3 R8 M", 2'b11, 1'b0, 1'b1, 0, 3'b100, 32'h8000_A5A5, 1'b1);
    ent_data = 16'h0F0F;
    access("R3 M virt", 2'b11, 1'b1, 1'b1, 0, 3'b100, 32'h8000_0F0F, 1'b1);
  endtask

  task automatic t_virt();
    ent_valid = 1'b1; ent_data = 16'h5555; useed_en = 1'b1;
    sseed_en = 1'b1;
    access("R4 VS sseed", 2'b01, 1'b1, 1'b1, 0, 3'b101, 0, 1'b0);
    access("R4 VU sseed", 2'b00, 1'b1, 1'b1, 0, 3'b101, 0, 1'b0);
    sseed_en = 1'b0;
    access("R4 VS nosseed", 2'b01, 1'b1, 1'b1, 0, 3'b110, 0, 1'b0);
    access("R4 R12 VU nosseed", 2'b00, 1'b1, 1'b1, 0, 3'b110, 0, 1'b0);
    useed_en = 1'b0;
  endtask

  task automatic t_super();
    ent_valid = 1'b1; ent_data = 16'h00FF;
    sseed_en = 1'b0; useed_en = 1'b1;
    access("R5 S off", 2'b01, 1'b0, 1'b1, 0, 3'b110, 0, 1'b0);
    sseed_en = 1'b1; useed_en = 1'b0;
    access("R5 S on", 2'b01, 1'b0, 1'b1, 0, 3'b100, 32'h8000_00FF, 1'b1);
    access("R5 reserved priv", 2'b10, 1'b0, 1'b1, 0, 3'b110, 0, 1'b0);
    sseed_en = 1'b0;
  endtask

  task automatic t_user();
    ent_valid = 1'b1; ent_data = 16'hBEEF;
    useed_en = 1'b0; sseed_en = 1'b1;
    access("R6 U off", 2'b00, 1'b0, 1'b1, 0, 3'b110, 0, 1'b0);
    useed_en = 1'b1; sseed_en = 1'b0;
    access("R6 U on", 2'b00, 1'b0, 1'b1, 0, 3'b100, 32'h8000_BEEF, 1'b1);
    useed_en = 1'b0;
  endtask

  task automatic t_wait();
    ent_valid = 1'b0; ent_data = 16'hFFFF;
    access("R9 M wait", 2'b11, 1'b0, 1'b1, 0, 3'b100, 32'h4000_0000, 1'b0);
  endtask

  task automatic t_wdata();
    ent_valid = 1'b1; ent_data = 16'h7E57;
    access("R11 wd0", 2'b11, 1'b0, 1'b1, 32'h0000_0000, 3'b100, 32'h8000_7E57, 1'b1);
    access("R11 wd1", 2'b11, 1'b0, 1'b1, 32'hFFFF_FFFF, 3'b100, 32'h8000_7E57, 1'b1);
  endtask

  task automatic t_dead();
    ent_valid = 1'b1; ent_data = 16'hCAFE;
    @(negedge clk); ent_err = 1'b1;
    @(negedge clk); ent_err = 1'b0;
    access("R10 dead", 2'b11, 1'b0, 1'b1, 0, 3'b100, 32'hC000_0000, 1'b0);
    repeat (5) @(negedge clk);
    access("R10 dead sticky", 2'b11, 1'b0, 1'b1, 0, 3'b100, 32'hC000_0000, 1'b0);
    do_reset();
    ent_valid = 1'b1; ent_data = 16'h1111;
    access("R13 after reset", 2'b11, 1'b0, 1'b1, 0, 3'b100, 32'h8000_1111, 1'b1);
  endtask

  task automatic t_dead_same_cycle();
    ent_valid = 1'b1; ent_data = 16'h2222;
    @(negedge clk);
    priv = 2'b11; virt = 1'b0; acc_wr = 1'b1; acc_valid = 1'b1; ent_err = 1'b1;
    #1 rdy_seen = ent_ready;
    @(negedge clk);
    acc_valid = 1'b0; ent_err = 1'b0;
    chk("R10 same cycle data", rsp_rdata, 32'hC000_0000);
    chk("R10 same cycle ready", {31'd0, rdy_seen}, 32'd0);
    do_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ext_off();
    t_read_only();
    t_machine();
    t_virt();
    t_super();
    t_user();
    t_wait();
    t_wdata();
    t_dead();
    t_dead_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule